// File: doc/BRIEF.md
# Gated-Clock Serial ADC Capture Controller

This block connects a sampling converter that runs as serial master to a host inside a larger chip. On the system clock it issues an active-low convert-start strobe. The strobe period and its low width are set in system clock cycles, and the strobe runs whether or not any data arrives. After each conversion the converter shifts its result out on a bit clock of its own. That clock toggles only while a word is in flight and stays idle between words. The converter also drives an active-low frame sync and one serial data line.

The block assembles each word in the bit-clock domain, MSB first, sampling data on rising bit-clock edges. Framing is late: the frame sync is low together with the first data bit. After enable, the first frame is read as a 15-bit word and every later frame as a 16-bit word. The first two words after enable are thrown away. Each later word crosses into the system clock domain through a toggle synchronizer, which does not need the stopped bit clock, and reaches the host as a one-cycle valid pulse with the data word.

Top module: `sadc_capture`

## Requirements
- R1: While reset is high or enable is low, `cnvStartN` is high and `wordValid` is low.
- R2: With enable high, and counting k system clock edges since enable was first seen high, `cnvStartN` is low after edge k exactly when (k-1) mod `periodCycles` < `lowCycles`. No input on the serial side changes this.
- R3: The first frame after enable is exactly 15 bits long. The frame that follows it starts its own 16-bit word.
- R4: Every later frame is 16 bits. Its first bit, sampled while `adcFsN` is low on a rising `adcSclk` edge, is bit 15 of `wordData`, and its last bit is bit 0.
- R5: The first two frames after enable never produce `wordValid`. Every later frame produces exactly one.
- R6: `wordValid` is high for exactly one system clock cycle per delivered word, within 8 system cycles of the word's last rising bit-clock edge, and `wordData` holds that word while it is high.
- R7: Dropping enable, or raising reset, returns the block to its first-word state. After re-enable, R3 and R5 apply again.
- R8: Rising bit-clock edges seen while no word is in progress and `adcFsN` is high are ignored. They produce no word and leave the next frame intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low returns to first-word state |
| periodCycles | input | CNT_W | Convert-start period in system cycles (>= 2) |
| lowCycles | input | CNT_W | Convert-start low width in system cycles (< periodCycles) |
| adcSclk | input | 1 | Gated bit clock from the converter |
| adcFsN | input | 1 | Active-low late frame sync from the converter |
| adcSdata | input | 1 | Serial data, changed on falling bit-clock edges |
| cnvStartN | output | 1 | Active-low convert-start strobe |
| wordValid | output | 1 | One-cycle pulse marking a delivered word |
| wordData | output | WORD_W | Delivered conversion result |

## Verification
Two functions can fall on the same system clock edge: the synchronized word-complete event that raises `wordValid`, and the falling edge of `cnvStartN` that starts the next conversion. The bench starts each frame a chosen number of cycles after a strobe falls and sweeps that offset, so the valid pulse lands before, on and after the next strobe edge. A behavioural model of the strobe timing and a queue of expected words are compared with the outputs on every clock. A collision therefore shows up as a shifted strobe, a doubled or lost pulse, or a wrong word.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  // Strobes from the system-side control to the bit-clock datapath
  typedef struct packed {
    logic clearBit;   // registered async clear for the bit-clock domain
  } capStrobes_t;
endpackage

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              adcSclk,
  input  logic              adcFsN,
  input  logic              adcSdata,
  input  capStrobes_t       strobes,
  output logic              wordTgl,
  output logic [WORD_W-1:0] holdData
);
  localparam int BC_W = $clog2(WORD_W) + 1;
  localparam logic [BC_W-1:0] LAST_LONG  = BC_W'(WORD_W - 1);
  localparam logic [BC_W-1:0] LAST_SHORT = BC_W'(WORD_W - 2);

  logic              clearBit;
  logic              inWord;
  logic              firstDone;
  logic [BC_W-1:0]   bitCnt;
  logic [WORD_W-2:0] shiftReg;
  logic [BC_W-1:0]   lastIdx;

  assign clearBit = strobes.clearBit;
  assign lastIdx  = firstDone ? LAST_LONG : LAST_SHORT;

  // Bit clock stops between frames, so the clear is asynchronous
  always_ff @(posedge adcSclk or posedge clearBit) begin
    if (clearBit) begin
      inWord    <= 1'b0;
      firstDone <= 1'b0;
      bitCnt    <= '0;
      shiftReg  <= '0;
      wordTgl   <= 1'b0;
      holdData  <= '0;
    end else if (!inWord) begin
      if (!adcFsN) begin
        shiftReg <= {shiftReg[WORD_W-3:0], adcSdata};
        bitCnt   <= BC_W'(1);
        inWord   <= 1'b1;
      end
    end else if (bitCnt == lastIdx) begin
      holdData  <= {shiftReg, adcSdata};
      wordTgl   <= ~wordTgl;
      inWord    <= 1'b0;
      firstDone <= 1'b1;
    end else begin
      shiftReg <= {shiftReg[WORD_W-3:0], adcSdata};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  // R8: an unframed edge while idle does not open a word
  p_idle_ignore_r8: assert property (@(posedge adcSclk) disable iff (clearBit)
    (!inWord && adcFsN) |=> !inWord);

  // R4: a completed word cannot be followed by another on the next edge
  p_one_flip_r4: assert property (@(posedge adcSclk) disable iff (clearBit)
    (wordTgl != $past(wordTgl)) |=> (wordTgl == $past(wordTgl)));
endmodule

// File: rtl/sadc_ctrl.sv
module sadc_ctrl
  import sadc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  periodCycles,
  input  logic [CNT_W-1:0]  lowCycles,
  input  logic              wordTgl,
  input  logic [WORD_W-1:0] holdData,
  output capStrobes_t       strobes,
  output logic              cnvStartN,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData
);
  localparam int SYNC_N = 3;
  localparam logic [1:0] DUMMY_N = 2'd2;

  logic [CNT_W-1:0]  divCnt;
  logic [SYNC_N-1:0] tglSync;
  logic              newWord;
  logic [1:0]        dummyCnt;
  logic              idle;

  assign idle    = rst || !en;
  assign newWord = tglSync[SYNC_N-1] ^ tglSync[SYNC_N-2];

  // Convert-start divider
  always_ff @(posedge clk) begin
    if (idle) begin
      divCnt    <= '0;
      cnvStartN <= 1'b1;
    end else begin
      divCnt    <= (divCnt >= periodCycles - 1'b1) ? '0 : divCnt + 1'b1;
      cnvStartN <= !(divCnt < lowCycles);
    end
  end

  // Clear for the bit-clock domain, registered to stay glitch-free
  always_ff @(posedge clk) strobes.clearBit <= idle;

  // Toggle synchronizer, dummy discard and host handshake
  always_ff @(posedge clk) begin
    if (idle) begin
      tglSync   <= '0;
      dummyCnt  <= '0;
      wordValid <= 1'b0;
      wordData  <= '0;
    end else begin
      tglSync   <= {tglSync[SYNC_N-2:0], wordTgl};
      wordValid <= 1'b0;
      if (newWord) begin
        if (dummyCnt != DUMMY_N) dummyCnt <= dummyCnt + 1'b1;
        else begin
          wordValid <= 1'b1;
          wordData  <= holdData;
        end
      end
    end
  end

  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnvStartN && !wordValid));

  p_strobe_enabled_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cnvStartN) |-> $past(en));

  p_dummy_done_r5: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> (dummyCnt == DUMMY_N));

  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);

  p_rearm_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> (dummyCnt == 2'd0));
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture
  import sadc_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  periodCycles,
  input  logic [CNT_W-1:0]  lowCycles,
  input  logic              adcSclk,
  input  logic              adcFsN,
  input  logic              adcSdata,
  output logic              cnvStartN,
  output logic              wordValid,
  output logic [WORD_W-1:0] wordData
);
  capStrobes_t       strobes;
  logic              wordTgl;
  logic [WORD_W-1:0] holdData;

  sadc_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst(rst), .en(en),
    .periodCycles(periodCycles), .lowCycles(lowCycles),
    .wordTgl(wordTgl), .holdData(holdData), .strobes(strobes),
    .cnvStartN(cnvStartN), .wordValid(wordValid), .wordData(wordData)
  );

  sadc_datapath #(.WORD_W(WORD_W)) dp_i (
    .adcSclk(adcSclk), .adcFsN(adcFsN), .adcSdata(adcSdata),
    .strobes(strobes), .wordTgl(wordTgl), .holdData(holdData)
  );
endmodule

// File: tb/sadc_capture_tb_top.sv
module sadc_capture_tb_top;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [CNT_W-1:0] periodCycles = 12'd60;
  logic [CNT_W-1:0] lowCycles    = 12'd3;
  logic adcSclk  = 1'b0;
  logic adcFsN   = 1'b1;
  logic adcSdata = 1'b0;
  logic cnvStartN, wordValid;
  logic [WORD_W-1:0] wordData;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  sadc_capture #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .periodCycles(periodCycles),
    .lowCycles(lowCycles), .adcSclk(adcSclk), .adcFsN(adcFsN),
    .adcSdata(adcSdata), .cnvStartN(cnvStartN), .wordValid(wordValid),
    .wordData(wordData)
  );

  // Reference state
  int          tEn = 0;
  int          dummySeen = 0;
  logic [15:0] expQ[$];
  bit          prevValid = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst || !en) tEn <= 0;
    else            tEn <= tEn + 1;
  end

  // Compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      bit expLow;
      expLow = (tEn >= 1) && (((tEn - 1) % int'(periodCycles)) < int'(lowCycles));
      check(cnvStartN == !expLow, "R2 strobe", cnvStartN, !expLow);
      if (tEn == 0) check(!wordValid, "R1 idle valid", wordValid, 0);
      if (wordValid) begin
        check(!prevValid, "R6 pulse width", prevValid, 0);
        check(expQ.size() != 0, "R5 unexpected word", expQ.size(), 1);
        if (expQ.size() != 0) begin
          check(wordData == expQ[0], "R4 word value", wordData, expQ[0]);
          void'(expQ.pop_front());
        end
      end
      prevValid = wordValid;
    end
  end

  task automatic clearModel();
    dummySeen = 0;
    expQ.delete();
  endtask

  // Converter-side frame: len bits of val, MSB first, late active-low sync
  task automatic sendFrame(input int len, input logic [15:0] val);
    for (int i = len - 1; i >= 0; i--) begin
      adcSdata = val[i];
      adcFsN   = (i == len - 1) ? 1'b0 : 1'b1;
      #4 adcSclk = 1'b1;
      #4 adcSclk = 1'b0;
    end
    adcFsN = 1'b1;
    if (dummySeen < 2) dummySeen++;
    else expQ.push_back(val);
  endtask

  task automatic frameAfterStrobe(input int delay, input int len, input logic [15:0] val);
    @(negedge cnvStartN);
    repeat (delay) @(posedge clk);
    #1;
    sendFrame(len, val);
  endtask

  task automatic drainCheck(input string req);
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, req, expQ.size(), 0);
  endtask

  task automatic setEn(input bit v);
    @(negedge clk);
    en = v;
    if (!v) clearModel();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(cnvStartN == 1'b1, "R1 reset strobe", cnvStartN, 1);
    check(wordValid == 1'b0, "R1 reset valid", wordValid, 0);
    @(negedge clk) rst = 1'b0;
    repeat (20) @(negedge clk);
    check(cnvStartN == 1'b1, "R1 disabled strobe", cnvStartN, 1);

    // R3/R5: 15-bit dummy, 16-bit dummy, then real words
    setEn(1);
    frameAfterStrobe(4, 15, 16'h5A5A);
    frameAfterStrobe(4, 16, 16'hFFFF);
    drainCheck("R5 dummies dropped");
    frameAfterStrobe(4, 16, 16'hA53C);
    drainCheck("R4 first real word");
    frameAfterStrobe(4, 16, 16'h8001);
    drainCheck("R4 msb lsb");
    frameAfterStrobe(4, 16, 16'h0000);
    drainCheck("R6 zero word");

    // Sweep so valid collides with the next strobe fall
    for (int d = 20; d <= 28; d++) begin
      frameAfterStrobe(d, 16, 16'h1234 + 16'(d * 16'h0111));
      drainCheck("R6 collision sweep");
    end

    // R8: stray unframed edges are ignored
    for (int k = 0; k < 3; k++) begin
      adcSdata = 1'b1;
      #4 adcSclk = 1'b1;
      #4 adcSclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    check(expQ.size() == 0 && !wordValid, "R8 no stray word", wordValid, 0);
    frameAfterStrobe(6, 16, 16'hC3E1);
    drainCheck("R8 next frame intact");

    // R7: disable mid-stream, re-enable with a new rate
    setEn(0);
    repeat (10) @(negedge clk);
    check(cnvStartN == 1'b1, "R7 disabled strobe", cnvStartN, 1);
    periodCycles = 12'd50;
    lowCycles    = 12'd5;
    setEn(1);
    frameAfterStrobe(3, 15, 16'h7FFF);
    frameAfterStrobe(3, 16, 16'h2222);
    drainCheck("R7 dummies after re-enable");
    frameAfterStrobe(3, 16, 16'h9E37);
    drainCheck("R3 word after short first");

    // R7: reset also re-arms
    @(negedge clk) rst = 1'b1;
    clearModel();
    repeat (3) @(negedge clk);
    @(negedge clk) rst = 1'b0;
    frameAfterStrobe(2, 15, 16'h0F0F);
    frameAfterStrobe(2, 16, 16'hF0F0);
    frameAfterStrobe(2, 16, 16'h6B2D);
    drainCheck("R7 after reset");

    // R2: strobe keeps running with no data
    repeat (200) @(negedge clk);
    check(expQ.size() == 0, "R2 idle run", expQ.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule